// File: doc/BRIEF.md
# Microwire Serial EEPROM Host Controller

This block sits on the host side of a Microwire serial EEPROM that stores 16-bit words. A client places a command code, a word address, a write word and a read word count on a single-cycle request interface. The block then drives chip select, serial clock and serial data out, and it samples the serial data returned by the memory. Each frame is made up of optional padding zeros, a start bit, a two-bit opcode and an address field. Write-type frames also carry a 16-bit data word. The serial clock runs at the system clock divided by twice `CLK_DIV`.

A read streams any number of consecutive words under one command. Chip select stays high and the clock keeps running while the memory advances its own address. Each word is handed out with a one-cycle valid strobe. After a command that programs the array, the block releases chip select for one serial-clock period. It then raises chip select again and watches the data line until the memory reports ready, or until a programmable limit expires. The end of every operation is marked by a one-cycle done pulse.

Top module: `mwEepromHost`

## Requirements
- R1: A request is taken only in a cycle where `reqReady` is high, and `reqReady` is high only while the block is idle with `cs` low. A `reqValid` pulse given while an operation runs starts no frame and changes nothing in the memory.
- R2: Every frame sends `PAD_BITS` zeros, then a 1, then a two-bit opcode, then `ADDR_W` address bits, all MSB first. The opcode is 10 for read (`reqCmd`=0), 01 for write (`reqCmd`=1) and 11 for erase (`reqCmd`=2).
- R3: The extended commands send opcode 00 and put a sub-code in the top two address positions, with every lower address bit sent as 0. The sub-codes are: write enable (`reqCmd`=3) 11, write disable (`reqCmd`=4) 00, write all (`reqCmd`=5) 01, erase all (`reqCmd`=6) 10.
- R4: Write and write-all frames are followed by the 16 bits of `reqData`, MSB first.
- R5: A read of `reqWords` words (a value of 0 counts as 1) keeps `cs` high for one dummy bit plus 16 bits per word. Each word, assembled MSB first, appears on `rdData` with a one-cycle `rdValid`, and `rdValid` is seen only while `cs` is high.
- R6: `sk` is low whenever `cs` is low. `di` never changes while `sk` is high. Each high phase of `sk` lasts exactly `CLK_DIV` clock cycles.
- R7: After write, erase, write-all or erase-all, `cs` stays low for exactly 2·`CLK_DIV` cycles. It then rises for polling, and `done` follows only after `doIn` is read as 1, with `errTimeout` low.
- R8: If `doIn` stays 0 through `busyTimeout` polling ticks, `cs` falls after exactly `busyTimeout`·`CLK_DIV` cycles of polling, and `done` pulses with `errTimeout` high in the same cycle.
- R9: `done` is a single-cycle pulse that is seen only with `cs` low. Read, write-enable and write-disable finish without a polling phase.
- R10: After reset, `cs`, `sk`, `di` and `done` are low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | High while idle and able to take a request |
| reqCmd | input | 3 | Command code: 0 read, 1 write, 2 erase, 3 write enable, 4 write disable, 5 write all, 6 erase all |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | 16 | Word to program |
| reqWords | input | CNT_W | Number of words to read |
| busyTimeout | input | TO_W | Polling limit in half serial-clock periods |
| done | output | 1 | One-cycle end-of-operation pulse |
| errTimeout | output | 1 | High with `done` when polling ran out |
| rdValid | output | 1 | One-cycle strobe for `rdData` |
| rdData | output | 16 | Read word |
| cs | output | 1 | Chip select to the memory |
| sk | output | 1 | Serial clock to the memory |
| di | output | 1 | Serial data to the memory |
| doIn | input | 1 | Serial data from the memory |

## Verification
All timing is set by a half-period tick every `CLK_DIV` cycles. The first `sk` rise comes `CLK_DIV` cycles after the request is taken. A read word's `rdValid` appears in the cycle right after the rising tick that samples its last bit. `done` appears in the cycle after the last falling tick of a non-programming frame, or after the polling tick that sees ready or runs out. The bench uses a behavioural memory model that runs every clock at the falling system-clock edge, away from the updates. It counts `cs` low and high lengths and `sk` high-phase lengths against the exact figures in R6 to R8, and it compares every captured frame bit with a list built from the command. After each `done`, it waits one more cycle before reading the model's measurements, so that each figure is read once it is complete.

// File: rtl/mwHostPkg.sv
package mwHostPkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_WEN   = 3'd3,
    CMD_WDS   = 3'd4,
    CMD_WRAL  = 3'd5,
    CMD_ERAL  = 3'd6
  } mwCmd_e;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;      // capture a new frame
    logic shiftTx;   // advance outgoing bit (falling tick)
    logic sampleRx;  // shift in one incoming bit (rising tick)
    logic wordOut;   // the sampled bit completes a word
  } mwStrobe_t;

endpackage

// File: rtl/mwHostPath.sv
module mwHostPath
  import mwHostPkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PAD_BITS = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwStrobe_t         stb,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqData,
  input  logic              doIn,
  output logic              di,
  output logic [15:0]       rdData,
  output logic              rdValid
);

  localparam int FRAME_W = PAD_BITS + 3 + ADDR_W + 16;

  logic [1:0]         opCode;
  logic [ADDR_W-1:0]  addrField;
  logic [15:0]        dataField;
  logic [FRAME_W-1:0] frameNext;
  logic [FRAME_W-1:0] txShift;
  logic [15:0]        rxShift;

  function automatic logic [ADDR_W-1:0] subField(input logic [1:0] sub);
    return {sub, {(ADDR_W-2){1'b0}}};
  endfunction

  always_comb begin
    opCode    = 2'b00;
    addrField = '0;
    case (reqCmd)
      CMD_READ:  begin opCode = 2'b10; addrField = reqAddr; end
      CMD_WRITE: begin opCode = 2'b01; addrField = reqAddr; end
      CMD_ERASE: begin opCode = 2'b11; addrField = reqAddr; end
      CMD_WEN:   addrField = subField(2'b11);
      CMD_WDS:   addrField = subField(2'b00);
      CMD_WRAL:  addrField = subField(2'b01);
      CMD_ERAL:  addrField = subField(2'b10);
      default:   addrField = '0;
    endcase
    dataField = (reqCmd == CMD_WRITE || reqCmd == CMD_WRAL) ? reqData : 16'h0000;
    // padding zeros sit above the start bit, so zero extension supplies them
    frameNext = FRAME_W'({1'b1, opCode, addrField, dataField});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.wordOut;
      if (stb.load)         txShift <= frameNext;
      else if (stb.shiftTx) txShift <= {txShift[FRAME_W-2:0], 1'b0};
      if (stb.sampleRx)     rxShift <= {rxShift[14:0], doIn};
      if (stb.wordOut)      rdData  <= {rxShift[14:0], doIn};
    end
  end

  assign di = txShift[FRAME_W-1];

endmodule

// File: rtl/mwHostCtrl.sv
module mwHostCtrl
  import mwHostPkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PAD_BITS = 0,
  parameter int CLK_DIV  = 4,
  parameter int CNT_W    = 4,
  parameter int TO_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqCmd,
  input  logic [CNT_W-1:0] reqWords,
  input  logic [TO_W-1:0]  busyTimeout,
  input  logic             doIn,
  output logic             reqReady,
  output logic             cs,
  output logic             sk,
  output logic             done,
  output logic             errTimeout,
  output mwStrobe_t        stb
);

  localparam int BASE_BITS = PAD_BITS + 3 + ADDR_W;
  localparam int MAX_BITS  = BASE_BITS + 17 + 16 * (2 ** CNT_W);
  localparam int BIT_W     = $clog2(MAX_BITS) + 1;
  localparam int DIV_W     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP, ST_POLL} state_e;

  state_e           state;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             accept;
  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] frameBits;
  logic [BIT_W-1:0] frameLen;
  logic [3:0]       wordBit;
  logic             rdMode;
  logic             progMode;
  logic             gapHalf;
  logic [TO_W-1:0]  toCnt;
  logic [TO_W-1:0]  toLimit;
  logic [CNT_W-1:0] effWords;
  logic             cmdRead;
  logic             cmdData;
  logic             cmdProg;
  logic             toExpire;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;
  assign tick     = (state != ST_IDLE) && (divCnt == DIV_W'(CLK_DIV - 1));
  assign toExpire = ({1'b0, toCnt} + (TO_W+1)'(1)) >= {1'b0, toLimit};

  always_comb begin
    cmdRead  = (reqCmd == CMD_READ);
    cmdData  = (reqCmd == CMD_WRITE) || (reqCmd == CMD_WRAL);
    cmdProg  = cmdData || (reqCmd == CMD_ERASE) || (reqCmd == CMD_ERAL);
    effWords = (reqWords == '0) ? CNT_W'(1) : reqWords;
    if (cmdRead)      frameLen = BIT_W'(BASE_BITS + 1) + BIT_W'({effWords, 4'b0000});
    else if (cmdData) frameLen = BIT_W'(BASE_BITS + 16);
    else              frameLen = BIT_W'(BASE_BITS);
  end

  always_comb begin
    stb          = '0;
    stb.load     = accept;
    stb.shiftTx  = tick && (state == ST_SHIFT) && sk;
    stb.sampleRx = tick && (state == ST_SHIFT) && !sk && rdMode &&
                   (bitCnt > BIT_W'(BASE_BITS));
    stb.wordOut  = stb.sampleRx && (wordBit == 4'd15);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      divCnt     <= '0;
      cs         <= 1'b0;
      sk         <= 1'b0;
      done       <= 1'b0;
      errTimeout <= 1'b0;
      bitCnt     <= '0;
      frameBits  <= '0;
      wordBit    <= '0;
      rdMode     <= 1'b0;
      progMode   <= 1'b0;
      gapHalf    <= 1'b0;
      toCnt      <= '0;
      toLimit    <= '0;
    end else begin
      done       <= 1'b0;
      errTimeout <= 1'b0;
      divCnt     <= (state == ST_IDLE || tick) ? '0 : divCnt + DIV_W'(1);
      case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_SHIFT;
          cs        <= 1'b1;
          bitCnt    <= '0;
          wordBit   <= '0;
          frameBits <= frameLen;
          rdMode    <= cmdRead;
          progMode  <= cmdProg;
          toLimit   <= busyTimeout;
        end
        ST_SHIFT: if (tick) begin
          if (!sk) begin
            sk     <= 1'b1;
            bitCnt <= bitCnt + BIT_W'(1);
            if (stb.sampleRx) wordBit <= wordBit + 4'd1;
          end else begin
            sk <= 1'b0;
            if (bitCnt == frameBits) begin
              cs <= 1'b0;
              if (progMode) begin
                state   <= ST_GAP;
                gapHalf <= 1'b0;
              end else begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end
          end
        end
        ST_GAP: if (tick) begin
          if (gapHalf) begin
            cs    <= 1'b1;
            state <= ST_POLL;
            toCnt <= '0;
          end
          gapHalf <= 1'b1;
        end
        ST_POLL: if (tick) begin
          if (doIn || toExpire) begin
            cs         <= 1'b0;
            state      <= ST_IDLE;
            done       <= 1'b1;
            errTimeout <= !doIn;
          end else begin
            toCnt <= toCnt + TO_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mwEepromHost.sv
module mwEepromHost
  import mwHostPkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int PAD_BITS = 0,
  parameter int CLK_DIV  = 4,
  parameter int CNT_W    = 4,
  parameter int TO_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqData,
  input  logic [CNT_W-1:0]  reqWords,
  input  logic [TO_W-1:0]   busyTimeout,
  output logic              done,
  output logic              errTimeout,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic              cs,
  output logic              sk,
  output logic              di,
  input  logic              doIn
);

  mwStrobe_t stb;

  mwHostCtrl #(
    .ADDR_W(ADDR_W), .PAD_BITS(PAD_BITS), .CLK_DIV(CLK_DIV),
    .CNT_W(CNT_W), .TO_W(TO_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqWords(reqWords), .busyTimeout(busyTimeout), .doIn(doIn),
    .reqReady(reqReady), .cs(cs), .sk(sk), .done(done),
    .errTimeout(errTimeout), .stb(stb)
  );

  mwHostPath #(.ADDR_W(ADDR_W), .PAD_BITS(PAD_BITS)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .reqCmd(reqCmd), .reqAddr(reqAddr),
    .reqData(reqData), .doIn(doIn), .di(di), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/mwEepromHostChk.sv
module mwEepromHostChk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic cs,
  input logic sk,
  input logic di,
  input logic done,
  input logic errTimeout,
  input logic rdValid
);

  AST_SK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN) !cs |-> !sk) else $error("sk high with cs low"); // R6
  AST_DI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN) (sk && $past(sk)) |-> $stable(di)) else $error("di moved while sk high"); // R6
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN) reqReady |-> !cs) else $error("ready during frame"); // R1
  AST_ACCEPT_FRAME: assert property (@(posedge clk) disable iff (!rstN) (reqValid && reqReady) |=> (cs && !reqReady)) else $error("request not taken"); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done) else $error("done longer than one cycle"); // R9
  AST_DONE_CS_LOW: assert property (@(posedge clk) disable iff (!rstN) done |-> !cs) else $error("done with cs high"); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN) errTimeout |-> done) else $error("error without done"); // R8
  AST_RDVALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN) rdValid |-> cs) else $error("read word outside frame"); // R5

endmodule

bind mwEepromHost mwEepromHostChk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cs(cs), .sk(sk), .di(di), .done(done), .errTimeout(errTimeout),
  .rdValid(rdValid)
);

// File: tb/tb_mwEepromHost.sv
`timescale 1ns/1ps
module tb_mwEepromHost;
  localparam int AW = 6, DIV = 3, PADN = 2, CW = 4, TW = 8, BUSYC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic reqValid = 0, reqReady, done, errTimeout, rdValid, cs, sk, di, doIn = 0;
  logic [2:0] reqCmd = 0;
  logic [AW-1:0] reqAddr = 0;
  logic [15:0] reqData = 0, rdData;
  logic [CW-1:0] reqWords = 0;
  logic [TW-1:0] busyTimeout = 8'd200;

  mwEepromHost #(.ADDR_W(AW), .PAD_BITS(PADN), .CLK_DIV(DIV), .CNT_W(CW), .TO_W(TW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqData(reqData), .reqWords(reqWords), .busyTimeout(busyTimeout),
    .done(done), .errTimeout(errTimeout), .rdValid(rdValid), .rdData(rdData),
    .cs(cs), .sk(sk), .di(di), .doIn(doIn));

  int nRun = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory model, run every clock ----------------
  int mem [64];
  bit wen = 0, forceBusy = 0, inRead = 0, readDo = 0;
  int busy = 0, rdAddr = 0, csRises = 0, protoErr = 0, frameMismatch = 0;
  int csHighLen = 0, csLowLen = 0, lastGap = 0, lastHigh = 0, skHighLen = 0;
  bit prevCs = 0, prevSk = 0, prevDi = 0;
  bit seen[$];
  bit expBits[$];
  logic [15:0] rdGot[$];

  function automatic int firstOne();
    foreach (seen[i]) if (seen[i]) return i;
    return -1;
  endfunction

  function automatic int field(input int from, input int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | int'(seen[from + i]);
    return v;
  endfunction

  task automatic setBusy();
    busy = forceBusy ? 1000000 : BUSYC;
  endtask

  task automatic endFrame();
    int s, op, a, sub;
    s = firstOne();
    if (s < 0) return;
    foreach (expBits[i]) if (i >= seen.size() || seen[i] != expBits[i]) frameMismatch++;
    op = field(s + 1, 2);
    a = field(s + 3, AW);
    sub = a >> (AW - 2);
    case (op)
      1: begin if (wen) mem[a] = field(s + 3 + AW, 16); setBusy(); end
      3: begin if (wen) mem[a] = 'hFFFF; setBusy(); end
      0: case (sub)
           3: wen = 1;
           0: wen = 0;
           1: begin if (wen) foreach (mem[i]) mem[i] = field(s + 3 + AW, 16); setBusy(); end
           default: begin if (wen) foreach (mem[i]) mem[i] = 'hFFFF; setBusy(); end
         endcase
      default: ;
    endcase
  endtask

  task automatic rdStep();
    int s, k;
    s = firstOne();
    if (s < 0) return;
    if (!inRead && seen.size() == s + 3 + AW && seen[s + 1] && !seen[s + 2]) begin
      inRead = 1;
      rdAddr = field(s + 3, AW);
      readDo = 0;
    end else if (inRead) begin
      k = seen.size() - (s + 3 + AW);
      readDo = mem[(rdAddr + (k - 1) / 16) % 64][15 - (k - 1) % 16];
    end
  endtask

  always @(negedge clk) begin
    if (busy > 0) busy--;
    if (rstN) begin
      if (cs && !prevCs) begin seen.delete(); lastGap = csLowLen; csHighLen = 0; csRises++; end
      if (!cs && prevCs) begin lastHigh = csHighLen; csLowLen = 0; endFrame(); inRead = 0; end
      if (cs) csHighLen++; else csLowLen++;
      if (!cs && sk) protoErr++;
      if (sk && prevSk && di != prevDi) protoErr++;
      if (sk) skHighLen++;
      if (!sk && prevSk) begin if (skHighLen != DIV) protoErr++; skHighLen = 0; end
      if (sk && !prevSk && cs) begin seen.push_back(di); rdStep(); end
    end
    doIn = inRead ? readDo : (cs && busy == 0);
    prevCs = cs; prevSk = sk; prevDi = di;
  end

  always @(negedge clk) if (rdValid) rdGot.push_back(rdData);

  // ---------------- stimulus helpers ----------------
  task automatic mkExp(input int cmd, input int addr, input int data);
    int op, af;
    expBits.delete();
    repeat (PADN) expBits.push_back(0);
    expBits.push_back(1);
    case (cmd)
      0: begin op = 2; af = addr; end
      1: begin op = 1; af = addr; end
      2: begin op = 3; af = addr; end
      3: begin op = 0; af = 3 << (AW - 2); end
      4: begin op = 0; af = 0; end
      5: begin op = 0; af = 1 << (AW - 2); end
      default: begin op = 0; af = 2 << (AW - 2); end
    endcase
    for (int i = 1; i >= 0; i--) expBits.push_back(op[i]);
    for (int i = AW - 1; i >= 0; i--) expBits.push_back(af[i]);
    if (cmd == 1 || cmd == 5) for (int i = 15; i >= 0; i--) expBits.push_back(data[i]);
  endtask

  bit gotErr;
  task automatic startOp(input int cmd, input int addr, input int data, input int nw);
    rdGot.delete();
    frameMismatch = 0;
    mkExp(cmd, addr, data);
    @(negedge clk);
    reqValid = 1; reqCmd = 3'(cmd); reqAddr = AW'(addr); reqData = 16'(data); reqWords = CW'(nw);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitDone(input string tag);
    int w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk({tag, " done seen"}, w < 20000, 1);
    gotErr = errTimeout;
    @(negedge clk);
  endtask

  task automatic runOp(input string tag, input int cmd, input int addr, input int data, input int nw);
    startOp(cmd, addr, data, nw);
    waitDone(tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int r0;
    foreach (mem[i]) mem[i] = 0;
    repeat (3) @(negedge clk);
    chk("R10 cs", cs, 0); chk("R10 sk", sk, 0); chk("R10 di", di, 0);
    chk("R10 done", done, 0); chk("R10 ready", reqReady, 1);
    rstN = 1;
    repeat (2) @(negedge clk);

    r0 = csRises;
    runOp("R3 wen", 3, 0, 0, 0);
    chk("R3 wen frame", frameMismatch, 0);
    chk("R9 wen no poll", csRises - r0, 1);
    chk("R9 wen err", gotErr, 0);

    r0 = csRises;
    runOp("R4 write", 1, 5, 'hA5C3, 0);
    chk("R2 write frame", frameMismatch, 0);
    chk("R4 write data", mem[5], 'hA5C3);
    chk("R7 gap length", lastGap, 2 * DIV);
    chk("R7 polled", csRises - r0, 2);
    chk("R7 ready seen", busy, 0);
    chk("R7 err low", gotErr, 0);

    runOp("R4 w6", 1, 6, 'h1234, 0);  chk("R4 w6", mem[6], 'h1234);
    runOp("R4 w7", 1, 7, 'hBEEF, 0);  chk("R4 w7", mem[7], 'hBEEF);
    runOp("R4 w63", 1, 63, 'h0F0F, 0); chk("R4 w63", mem[63], 'h0F0F);
    runOp("R4 w0", 1, 0, 'hC001, 0);  chk("R4 w0", mem[0], 'hC001);

    r0 = csRises;
    runOp("R5 read3", 0, 5, 0, 3);
    chk("R2 read frame", frameMismatch, 0);
    chk("R5 read3 count", rdGot.size(), 3);
    chk("R9 read no poll", csRises - r0, 1);
    chk("R5 read3 len", lastHigh, (PADN + 3 + AW + 1 + 48) * 2 * DIV);
    if (rdGot.size() == 3) begin
      chk("R5 word0", rdGot[0], 'hA5C3);
      chk("R5 word1", rdGot[1], 'h1234);
      chk("R5 word2", rdGot[2], 'hBEEF);
    end

    runOp("R5 read wrap", 0, 63, 0, 2);
    chk("R5 wrap count", rdGot.size(), 2);
    if (rdGot.size() == 2) begin
      chk("R5 wrap w0", rdGot[0], 'h0F0F);
      chk("R5 wrap w1", rdGot[1], 'hC001);
    end

    runOp("R2 erase", 2, 6, 0, 0);
    chk("R2 erase frame", frameMismatch, 0);
    chk("R7 erase effect", mem[6], 'hFFFF);

    runOp("R3 wral", 5, 0, 'h5A5A, 0);
    chk("R3 wral frame", frameMismatch, 0);
    chk("R4 wral data", mem[40], 'h5A5A);
    runOp("R5 read1", 0, 10, 0, 1);
    chk("R5 read1 count", rdGot.size(), 1);
    if (rdGot.size() == 1) chk("R5 read1 word", rdGot[0], 'h5A5A);

    runOp("R3 eral", 6, 0, 0, 0);
    chk("R3 eral frame", frameMismatch, 0);
    chk("R3 eral effect", mem[33], 'hFFFF);

    busyTimeout = 8'd5;
    forceBusy = 1;
    runOp("R8 timeout", 1, 9, 'h1111, 0);
    chk("R8 err flag", gotErr, 1);
    chk("R8 poll length", lastHigh, 5 * DIV);
    forceBusy = 0;
    busy = 0;
    busyTimeout = 8'd200;

    r0 = csRises;
    startOp(1, 12, 'h7777, 0);
    repeat (10) @(negedge clk);
    chk("R1 busy not ready", reqReady, 0);
    reqCmd = 3'd5; reqData = 16'h0000; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    waitDone("R1 run");
    chk("R1 ignored frames", csRises - r0, 2);
    chk("R1 target kept", mem[12], 'h7777);
    chk("R1 other kept", mem[13], 'hFFFF);

    runOp("R3 wds", 4, 0, 0, 0);
    chk("R3 wds frame", frameMismatch, 0);

    chk("R6 protocol errors", protoErr, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule